// File: doc/BRIEF.md
# Clock Mode and Wake-Up Controller

This block picks the system clock of a small processor and sequences its deep-sleep and wake-up. Software writes one 16-bit control word over a simple register bus. The word sets four things: a PLL multiplier, the choice between the crystal and the PLL path, a divide option for the PLL path, and stop controls for the oscillator and the VCO. It also selects which wake pins are armed and the level that wakes the device. The analog oscillator and PLL sit outside the block. They arrive as single-cycle tick inputs on a fast, always-running reference clock: one tick per VCO cycle, one per crystal cycle, and one per half crystal cycle. The block returns stop-enable outputs to them and passes them the clamped multiplier.

The block's output is a one-cycle system clock enable on the reference clock. When the oscillator and the VCO are both stopped, the block enters deep sleep and the enable goes quiet. An armed wake pin that reaches the programmed level then restarts the clocks. The block holds the core in reset for a fixed settling window and then lets it run from its reset vector. A change of clock selection waits for the divide-by-4 phase boundary, so no runt enable is ever produced.

Top module: `clkmode_wake_ctrl`

## Requirements
- R1: During reset and for 16 reference cycles after reset release, `core_rst_n` is low. It counts from the cycle in which `rst_n` rises. After reset the control word reads 0x0000, `osc_stop` and `vco_stop` are 0 and `sys_clk_en` is 0.
- R2: The control word bit layout is: bits 15:8 multiplier, bit 7 wake level (1 = high), bits 6:5 wake source, bits 4:3 PLL output select, bit 2 oscillator stop, bit 1 VCO stop, bit 0 clock source (1 = PLL path). A write while running is read back unchanged on `rd_data`. `pll_mult` shows bits 15:8 clamped to the range 1 to 156.
- R3: With bit 0 = 0, `sys_clk_en` pulses once, one cycle after each `xtal_tick`, whatever the output select holds. In that mode `vco_tick` and `xtal2_tick` produce no enable.
- R4: With bit 0 = 1, output select 00 gives one enable per `vco_tick`. 01 gives one enable per 2 VCO ticks, 10 gives one per 4, and 11 gives one per `xtal2_tick`.
- R5: While the block is running and the VCO is not stopped, a new clock source or output select takes effect only at the VCO tick that ends a divide-by-4 period. That tick still uses the old selection. The divide count starts at 0 after reset.
- R6: `osc_stop` follows bit 2 and `vco_stop` follows bit 1 while the block is running.
- R7: A control word with both bits 2 and 1 set puts the block in deep sleep. There `osc_stop` and `vco_stop` are 1, `sys_clk_en` stays 0 and `core_rst_n` stays high.
- R8: In deep sleep, wake source 00 never wakes the block; only `rst_n` ends the sleep. Source 01 arms `wake_pin[0]`, 10 arms `wake_pin[1]`, and 11 arms all three pins. A pin counts only at the level given by bit 7.
- R9: Each wake pin passes through a two-stage synchronizer. A wake needs the armed, synchronized level to match for two consecutive cycles, so a one-cycle pulse does not wake the block.
- R10: On wake, bits 2 and 1 are cleared and the other fields are kept. `core_rst_n` is then low for exactly 16 cycles, during which `sys_clk_en` stays 0.
- R11: Register writes are ignored while the block is asleep or holding the core in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Current control word |
| vco_tick | input | 1 | One-cycle pulse per VCO cycle |
| xtal_tick | input | 1 | One-cycle pulse per crystal cycle |
| xtal2_tick | input | 1 | One-cycle pulse at twice the crystal rate |
| wake_pin | input | 3 | Asynchronous wake pins (0, 1, 2) |
| pll_mult | output | 8 | Clamped PLL multiplier |
| osc_stop | output | 1 | Stop request to the oscillator |
| vco_stop | output | 1 | Stop request to the VCO |
| sys_clk_en | output | 1 | System clock enable pulse |
| core_rst_n | output | 1 | Active-low core reset |

## Verification
The assertions take three things for granted about the inputs. The tick inputs are single-cycle pulses on the reference clock. Wake pins may change at any time. Software writes the control word only while the core is running. The stimulus drives every input on the falling clock edge, sends each tick as one high cycle followed by at least one low cycle, and holds each wake level for many cycles. The one exception is the deliberate one-cycle glitch. Writes that target sleep or the reset hold are made only to show that they are ignored.

// File: rtl/ckm_pkg.sv
// Package: shared types for the clock mode and wake-up controller.
// Assumes a fixed 16-bit control word whose field order software relies on.
package ckm_pkg;

    localparam int CTRL_W    = 16;
    localparam int MULT_W    = 8;
    localparam int WAKE_PINS = 3;

    typedef enum logic [1:0] {
        OUT_VCO   = 2'b00,
        OUT_DIV2  = 2'b01,
        OUT_DIV4  = 2'b10,
        OUT_XTAL2 = 2'b11
    } out_sel_e;

    typedef enum logic [1:0] {
        WSRC_POR  = 2'b00,
        WSRC_PINA = 2'b01,
        WSRC_PINB = 2'b10,
        WSRC_ANY  = 2'b11
    } wake_src_e;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'b00,
        ST_RUN   = 2'b01,
        ST_SLEEP = 2'b10
    } ckm_state_e;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic              wake_lvl;
        wake_src_e         wake_src;
        out_sel_e          out_sel;
        logic              stop_osc;
        logic              stop_vco;
        logic              use_pll;
    } ctrl_t;

endpackage

// File: rtl/ckm_ctrl_reg.sv
// Control register: stores the 16-bit control word and clamps the multiplier.
// Assumes writes are accepted only while the sequencer reports running; the
// sequencer clears the two stop bits in the cycle it leaves deep sleep.
module ckm_ctrl_reg
    import ckm_pkg::*;
#(
    parameter int MULT_MIN = 1,
    parameter int MULT_MAX = 156
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTRL_W-1:0]   wr_data,
    input  logic                accept_i,
    input  logic                clr_stop_i,
    output ctrl_t               ctrl_o,
    output logic [MULT_W-1:0]   mult_o
);

    localparam logic [MULT_W-1:0] MIN_V = MULT_W'(MULT_MIN);
    localparam logic [MULT_W-1:0] MAX_V = MULT_W'(MULT_MAX);

    ctrl_t ctrl_q;

    // Hold the control word: load on accepted writes, drop stop bits on wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (accept_i && wr_en) begin
            ctrl_q <= ctrl_t'(wr_data);
        end else if (clr_stop_i) begin
            ctrl_q.stop_osc <= 1'b0;
            ctrl_q.stop_vco <= 1'b0;
        end
    end

    // Limit the multiplier seen by the PLL to its legal range.
    always_comb begin
        if (ctrl_q.mult < MIN_V)
            mult_o = MIN_V;
        else if (ctrl_q.mult > MAX_V)
            mult_o = MAX_V;
        else
            mult_o = ctrl_q.mult;
    end

    assign ctrl_o = ctrl_q;

    // R11
    write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && !clr_stop_i) |=> $stable(ctrl_q));

endmodule

// File: rtl/ckm_clk_gen.sv
// Clock enable generator: divides the VCO tick stream and picks the source.
// Assumes tick inputs are single-cycle pulses on clk. The selection changes
// only at the end of a divide-by-4 period unless apply is forced.
module ckm_clk_gen
    import ckm_pkg::*;
#(
    parameter int DIV_MAX = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vco_tick,
    input  logic      xtal_tick,
    input  logic      xtal2_tick,
    input  logic      want_pll_i,
    input  out_sel_e  want_out_i,
    input  logic      force_apply_i,
    input  logic      run_nxt_i,
    output logic      clk_en_o
);

    localparam int                 CNT_W = $clog2(DIV_MAX);
    localparam logic [CNT_W-1:0]   LAST  = CNT_W'(DIV_MAX - 1);

    logic [CNT_W-1:0] div_cnt_q;
    logic             act_pll_q;
    out_sel_e         act_out_q;
    logic             boundary;
    logic             apply;
    logic             pll_pulse;
    logic             pulse;
    logic             en_q;

    assign boundary = vco_tick && (div_cnt_q == LAST);
    assign apply    = boundary || force_apply_i;

    // Count VCO ticks modulo the largest divide ratio.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_cnt_q <= '0;
        else if (vco_tick)
            div_cnt_q <= div_cnt_q + CNT_W'(1);
    end

    // Adopt the requested selection only at a safe point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pll_q <= 1'b0;
            act_out_q <= OUT_VCO;
        end else if (apply) begin
            act_pll_q <= want_pll_i;
            act_out_q <= want_out_i;
        end
    end

    // Pick the PLL-path pulse for the active output option.
    always_comb begin
        unique case (act_out_q)
            OUT_VCO:   pll_pulse = vco_tick;
            OUT_DIV2:  pll_pulse = vco_tick && div_cnt_q[0];
            OUT_DIV4:  pll_pulse = boundary;
            OUT_XTAL2: pll_pulse = xtal2_tick;
            default:   pll_pulse = 1'b0;
        endcase
    end

    assign pulse = act_pll_q ? pll_pulse : xtal_tick;

    // Register the enable, gated by whether the core runs next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else
            en_q <= pulse && run_nxt_i;
    end

    assign clk_en_o = en_q;

    // R5
    sel_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({act_pll_q, act_out_q}) |-> $past(apply));

endmodule

// File: rtl/ckm_wake.sv
// Wake detector: synchronizes the wake pins and filters the armed match.
// Assumes the pins are asynchronous. A wake needs two consecutive matching
// synchronized samples while the sequencer reports deep sleep.
module ckm_wake
    import ckm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WAKE_PINS-1:0] pin_i,
    input  logic                 lvl_i,
    input  wake_src_e            src_i,
    input  logic                 asleep_i,
    output logic                 wake_o
);

    logic [WAKE_PINS-1:0] level;
    logic [WAKE_PINS-1:0] match;
    logic                 hit;
    logic                 hit_q;

    for (genvar p = 0; p < WAKE_PINS; p++) begin : g_sync
        logic [SYNC_STAGES-1:0] sq;

        // Shift the raw pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sq <= '0;
            else
                sq <= {sq[SYNC_STAGES-2:0], pin_i[p]};
        end

        assign level[p] = sq[SYNC_STAGES-1];
    end

    assign match = lvl_i ? level : ~level;

    // Decode which synchronized pins may wake the core.
    always_comb begin
        unique case (src_i)
            WSRC_POR:  hit = 1'b0;
            WSRC_PINA: hit = match[0];
            WSRC_PINB: hit = match[1];
            WSRC_ANY:  hit = |match;
            default:   hit = 1'b0;
        endcase
    end

    // Remember the previous match for the two-sample filter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hit_q <= 1'b0;
        else
            hit_q <= hit;
    end

    assign wake_o = asleep_i && hit && hit_q;

    // R8
    por_only_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (src_i != WSRC_POR));

endmodule

// File: rtl/ckm_seq.sv
// Sequencer: tracks reset hold, running and deep sleep.
// Assumes sleep_req stays set until the wake that clears the stop bits.
// Reset and wake both pass through a fixed hold before the core runs.
module ckm_seq
    import ckm_pkg::*;
#(
    parameter int HOLD_TICKS = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sleep_req_i,
    input  logic  wake_i,
    output logic  run_o,
    output logic  run_nxt_o,
    output logic  asleep_o,
    output logic  clr_stop_o,
    output logic  core_rst_n_o
);

    localparam int                HCNT_W    = $clog2(HOLD_TICKS);
    localparam logic [HCNT_W-1:0] HOLD_LAST = HCNT_W'(HOLD_TICKS - 1);

    ckm_state_e        state_q;
    ckm_state_e        state_d;
    logic [HCNT_W-1:0] hold_cnt_q;

    // Choose the next mode from the current mode and its events.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (hold_cnt_q == HOLD_LAST) state_d = ST_RUN;
            ST_RUN:   if (sleep_req_i)             state_d = ST_SLEEP;
            ST_SLEEP: if (wake_i)                  state_d = ST_HOLD;
            default:                               state_d = ST_HOLD;
        endcase
    end

    // Advance the mode register; reset starts a hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_HOLD;
        else
            state_q <= state_d;
    end

    // Count cycles spent holding the core in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_cnt_q <= '0;
        else if (state_q == ST_HOLD)
            hold_cnt_q <= hold_cnt_q + HCNT_W'(1);
        else
            hold_cnt_q <= '0;
    end

    assign run_o        = (state_q == ST_RUN);
    assign run_nxt_o    = (state_d == ST_RUN);
    assign asleep_o     = (state_q == ST_SLEEP);
    assign clr_stop_o   = (state_q == ST_SLEEP) && wake_i;
    assign core_rst_n_o = (state_q != ST_HOLD);

    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n_o) |-> ($past(hold_cnt_q) == HOLD_LAST));

endmodule

// File: rtl/clkmode_wake_ctrl.sv
// Top: clock mode and wake-up controller.
// Wires the control register, enable generator, wake detector and sequencer.
// Assumes all tick inputs are synchronous single-cycle pulses on clk.
module clkmode_wake_ctrl
    import ckm_pkg::*;
#(
    parameter int HOLD_TICKS  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MULT_MIN    = 1,
    parameter int MULT_MAX    = 156
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CTRL_W-1:0]    wr_data,
    output logic [CTRL_W-1:0]    rd_data,
    input  logic                 vco_tick,
    input  logic                 xtal_tick,
    input  logic                 xtal2_tick,
    input  logic [WAKE_PINS-1:0] wake_pin,
    output logic [MULT_W-1:0]    pll_mult,
    output logic                 osc_stop,
    output logic                 vco_stop,
    output logic                 sys_clk_en,
    output logic                 core_rst_n
);

    ctrl_t ctrl;
    logic  run;
    logic  run_nxt;
    logic  asleep;
    logic  clr_stop;
    logic  wake;
    logic  sleep_req;
    logic  force_apply;

    assign sleep_req   = ctrl.stop_osc && ctrl.stop_vco;
    assign force_apply = ctrl.stop_vco || !run;

    ckm_ctrl_reg #(
        .MULT_MIN (MULT_MIN),
        .MULT_MAX (MULT_MAX)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .accept_i   (run),
        .clr_stop_i (clr_stop),
        .ctrl_o     (ctrl),
        .mult_o     (pll_mult)
    );

    ckm_clk_gen #(
        .DIV_MAX (4)
    ) u_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .vco_tick      (vco_tick),
        .xtal_tick     (xtal_tick),
        .xtal2_tick    (xtal2_tick),
        .want_pll_i    (ctrl.use_pll),
        .want_out_i    (ctrl.out_sel),
        .force_apply_i (force_apply),
        .run_nxt_i     (run_nxt),
        .clk_en_o      (sys_clk_en)
    );

    ckm_wake #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (wake_pin),
        .lvl_i    (ctrl.wake_lvl),
        .src_i    (ctrl.wake_src),
        .asleep_i (asleep),
        .wake_o   (wake)
    );

    ckm_seq #(
        .HOLD_TICKS (HOLD_TICKS)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req_i  (sleep_req),
        .wake_i       (wake),
        .run_o        (run),
        .run_nxt_o    (run_nxt),
        .asleep_o     (asleep),
        .clr_stop_o   (clr_stop),
        .core_rst_n_o (core_rst_n)
    );

    assign rd_data  = ctrl;
    assign osc_stop = ctrl.stop_osc;
    assign vco_stop = ctrl.stop_vco;

    // R7
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (osc_stop && vco_stop && !sys_clk_en && core_rst_n));

    // R10
    hold_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |-> !sys_clk_en);

endmodule

// File: tb/clkmode_wake_ctrl_tb.sv
// Directed bench for the clock mode and wake-up controller.
module clkmode_wake_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        vco_tick = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        xtal2_tick = 1'b0;
    logic [2:0]  wake_pin = '0;
    logic [7:0]  pll_mult;
    logic        osc_stop;
    logic        vco_stop;
    logic        sys_clk_en;
    logic        core_rst_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    clkmode_wake_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .vco_tick   (vco_tick),
        .xtal_tick  (xtal_tick),
        .xtal2_tick (xtal2_tick),
        .wake_pin   (wake_pin),
        .pll_mult   (pll_mult),
        .osc_stop   (osc_stop),
        .vco_stop   (vco_stop),
        .sys_clk_en (sys_clk_en),
        .core_rst_n (core_rst_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    // kind 0: vco, 1: xtal, 2: xtal2; returns enable pulses seen
    task automatic burst(input int kind, input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            case (kind)
                0: vco_tick = 1'b1;
                1: xtal_tick = 1'b1;
                default: xtal2_tick = 1'b1;
            endcase
            @(negedge clk);
            if (sys_clk_en) pulses++;
            vco_tick = 1'b0;
            xtal_tick = 1'b0;
            xtal2_tick = 1'b0;
            @(negedge clk);
            if (sys_clk_en) pulses++;
        end
    endtask

    // Wait for the core reset to assert, then measure its length.
    task automatic wait_wake(input string req, output int low_len);
        int guard = 0;
        int bad_en = 0;
        while (core_rst_n && guard < 12) begin
            @(negedge clk);
            guard++;
        end
        low_len = 0;
        xtal_tick = 1'b1;
        while (!core_rst_n && low_len < 40) begin
            low_len++;
            if (sys_clk_en) bad_en++;
            @(negedge clk);
        end
        xtal_tick = 1'b0;
        chk(req, "enable during hold", bad_en, 0);
    endtask

    task automatic test_reset();
        int len = 0;
        rst_n = 1'b0;
        idle(4);
        chk("R1", "core_rst_n in reset", core_rst_n, 0);
        chk("R1", "sys_clk_en in reset", sys_clk_en, 0);
        rst_n = 1'b1;
        while (!core_rst_n && len < 40) begin
            len++;
            @(negedge clk);
        end
        chk("R1", "hold after reset", len, 16);
        chk("R1", "control word", rd_data, 16'h0000);
        chk("R1", "osc_stop", osc_stop, 0);
        chk("R1", "vco_stop", vco_stop, 0);
    endtask

    task automatic test_osc_direct();
        int p;
        burst(1, 5, p);
        chk("R3", "xtal direct pulses", p, 5);
        burst(2, 3, p);
        chk("R3", "xtal2 ignored in direct", p, 0);
    endtask

    task automatic test_boundary();
        int p;
        wr(16'h0001);
        burst(0, 3, p);
        chk("R5", "before boundary", p, 0);
        burst(0, 1, p);
        chk("R5", "boundary tick uses old select", p, 0);
        burst(0, 4, p);
        chk("R5", "after boundary", p, 4);
    endtask

    task automatic test_out_sel();
        int p;
        for (int s = 0; s < 3; s++) begin
            wr(16'h0001 | 16'(s << 3));
            burst(0, 4, p);
            idle(2);
            burst(0, 16, p);
            chk("R4", $sformatf("vco select %0d", s), p, 16 >> s);
        end
        wr(16'h0019);
        burst(0, 4, p);
        idle(2);
        burst(2, 6, p);
        chk("R4", "twice crystal", p, 6);
        burst(0, 8, p);
        chk("R4", "vco ignored at twice crystal", p, 0);
        wr(16'h0018);
        burst(0, 4, p);
        idle(2);
        burst(1, 4, p);
        chk("R3", "bypass ignores out select", p, 4);
    endtask

    task automatic test_mult();
        wr(16'h5A00);
        chk("R2", "readback", rd_data, 16'h5A00);
        chk("R2", "mult mid", pll_mult, 8'h5A);
        wr(16'h0000);
        chk("R2", "mult clamp low", pll_mult, 1);
        wr(16'hFF00);
        chk("R2", "readback raw", rd_data, 16'hFF00);
        chk("R2", "mult clamp high", pll_mult, 156);
        wr(16'h9C00);
        chk("R2", "mult max", pll_mult, 156);
        wr(16'h0100);
        chk("R2", "mult min", pll_mult, 1);
    endtask

    task automatic test_stops();
        wr(16'h0004);
        chk("R6", "osc_stop set", osc_stop, 1);
        chk("R6", "vco_stop clear", vco_stop, 0);
        chk("R6", "still running", core_rst_n, 1);
        wr(16'h0002);
        chk("R6", "osc_stop clear", osc_stop, 0);
        chk("R6", "vco_stop set", vco_stop, 1);
        wr(16'h0000);
        chk("R6", "both clear", {osc_stop, vco_stop}, 0);
    endtask

    task automatic test_sleep_pin_a();
        int p;
        int len;
        wake_pin = 3'b000;
        wr(16'h00A6);
        idle(2);
        chk("R7", "stops in sleep", {osc_stop, vco_stop}, 3);
        chk("R7", "core_rst_n in sleep", core_rst_n, 1);
        burst(1, 4, p);
        chk("R7", "no enable in sleep", p, 0);
        wr(16'h0000);
        chk("R11", "write ignored in sleep", rd_data, 16'h00A6);
        wake_pin = 3'b010;
        idle(10);
        chk("R8", "unarmed pin no wake", {osc_stop, core_rst_n}, 3);
        wake_pin = 3'b011;
        wait_wake("R10", len);
        chk("R10", "hold length", len, 16);
        chk("R10", "stop bits cleared", rd_data, 16'h00A0);
        chk("R8", "pin 0 high wakes", osc_stop, 0);
        wake_pin = 3'b000;
    endtask

    task automatic test_wake_b_low();
        int len;
        wake_pin = 3'b111;
        wr(16'h0046);
        idle(2);
        wake_pin = 3'b110;
        idle(10);
        chk("R8", "low level on unarmed pin", {osc_stop, core_rst_n}, 3);
        wake_pin = 3'b100;
        wait_wake("R8", len);
        chk("R8", "pin 1 low wakes", len, 16);
        chk("R8", "fields kept", rd_data, 16'h0040);
        wake_pin = 3'b000;
    endtask

    task automatic test_wake_any();
        int len;
        wake_pin = 3'b000;
        wr(16'h00E6);
        idle(2);
        wake_pin = 3'b100;
        wait_wake("R8", len);
        chk("R8", "pin 2 wakes on any", len, 16);
        wake_pin = 3'b000;
    endtask

    task automatic test_glitch();
        int len;
        wake_pin = 3'b000;
        wr(16'h00A6);
        idle(2);
        wake_pin = 3'b001;
        @(negedge clk);
        wake_pin = 3'b000;
        idle(10);
        chk("R9", "one-cycle pulse ignored", {osc_stop, core_rst_n}, 3);
        wake_pin = 3'b001;
        wait_wake("R9", len);
        chk("R9", "held level wakes", len, 16);
        wake_pin = 3'b000;
    endtask

    task automatic test_por_only();
        int len = 0;
        wr(16'h0086);
        idle(2);
        wake_pin = 3'b111;
        idle(12);
        chk("R8", "por-only ignores pins", {osc_stop, core_rst_n}, 3);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        while (!core_rst_n && len < 40) begin
            len++;
            @(negedge clk);
        end
        chk("R1", "hold after reset from sleep", len, 16);
        chk("R1", "word cleared", rd_data, 16'h0000);
        wake_pin = 3'b000;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_osc_direct();
        test_boundary();
        test_out_sel();
        test_mult();
        test_stops();
        test_sleep_pin_a();
        test_wake_b_low();
        test_wake_any();
        test_glitch();
        test_por_only();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule